// File: doc/BRIEF.md
# Card Presence and Supply Sequencing Controller

This block sits between a host controller and a smart card socket. It watches the socket's presence switch, filters switch bounce with a long counter, and raises an active-low interrupt each time a card arrives or leaves. It also runs the card's power-up and power-down order. The host asks for a session by holding its select line low and giving a rising edge on its power request. The block then turns on the card supply. It waits for the converter to report a good supply before it lets the card clock and data line go. Card reset stays low until the host raises it.

Two events end a session without the host asking: the card being pulled out, or the battery flag dropping while a session is open. Either one starts the same ordered shutdown and sets the interrupt. Until the battery flag is good, no session can start and presence changes are not accepted. A small status output, addressed by two select bits, lets the host read the filtered card state, the battery state (reported in negative logic) or the converter state. The converter and the analog comparators are outside the block and appear only as input flags.

Top module: `card_pwr_seq`

## Requirements
- R1: After reset, `vcc_en`, `clk_en`, `crd_rst` and `crd_io` are 0, `irq_n` is 1, and `status` is 1.
- R2: With `pol_hi`=0, a low synchronised `det_in` means a card is present. With `pol_hi`=1, a high `det_in` means a card is present.
- R3: A presence change is accepted only after the synchronised raw presence has differed from the accepted state for DEBOUNCE_CYC cycles in a row. A shorter excursion has no effect on `irq_n` or on the card-present status.
- R4: Each accepted insertion or removal drives `irq_n` low. It stays low until a cycle with `irq_clr`=1, and then returns high.
- R5: In the idle state, when a card is present and the battery is good, `cs_n`=0 with a rising edge on `pwr_req` sets `vcc_en`. `clk_en` and `crd_io` stay 0 until `vcc_good` is seen. After that `clk_en` is 1 and `crd_io` follows `host_io`.
- R6: `crd_rst` is 1 only during an active session while `host_rst`=1. The block never raises it by itself.
- R7: With `cs_n`=0 and `pwr_req`=0 during a session, shutdown runs in this order: `crd_rst` low, then `clk_en` low, then `crd_io` low, then `vcc_en` low. The last three steps each follow the previous one by exactly STEP_CYC cycles.
- R8: Accepted card removal during a session starts the R7 shutdown whatever the level of `pwr_req`, and sets the interrupt.
- R9: While `bat_ok`=0, no session starts and presence changes are not accepted. A fall of `bat_ok` during a session starts the R7 shutdown and sets the interrupt.
- R10: `status` is 1 when `cs_n`=1. With `cs_n`=0 it shows: for `addr`=0, card present (1 = present); for `addr`=1, the inverse of the battery flag (0 = battery good); for `addr`=2, `vcc_good`; for `addr`=3, 1.
- R11: A rising `pwr_req` is ignored while `cs_n`=1 or while no card is present, and `vcc_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_in | input | 1 | Raw socket presence switch |
| pol_hi | input | 1 | Presence polarity: 0 = low means present, 1 = high means present |
| cs_n | input | 1 | Host select, active low |
| pwr_req | input | 1 | Host power request; a rising edge starts a session |
| host_rst | input | 1 | Card reset level wanted by the host |
| host_io | input | 1 | Data line level forced by the host |
| irq_clr | input | 1 | Clears the interrupt latch |
| addr | input | 2 | Status source select |
| bat_ok | input | 1 | Battery-good flag from the analog side |
| vcc_good | input | 1 | Card supply good flag from the converter |
| vcc_en | output | 1 | Card supply enable |
| clk_en | output | 1 | Card clock enable |
| crd_rst | output | 1 | Card reset line |
| crd_io | output | 1 | Card data line level |
| irq_n | output | 1 | Interrupt, active low |
| status | output | 1 | Multiplexed status bit |

## Verification
Some rules are checked on every cycle. These are the rules that tie outputs together: clock and data only with supply, reset only with clock, and the supply going off last. Also checked each cycle: an accepted presence event is followed by the interrupt, removal in a session moves to shutdown, a session only starts with a present card and a good battery, and status is idle-high when not selected. Only the bench scenarios can show the rest. That covers the exact step spacing and the full order of a shutdown as seen at the ports, and that a short bounce is filtered out. It also covers both polarities, the status codes, and that requests are ignored without select, without a card or with a bad battery.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PWR_UP = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_DN_RST = 3'd3,
    ST_DN_CLK = 3'd4,
    ST_DN_IO  = 3'd5
  } pwr_st_e;

  localparam logic [1:0] SEL_CARD = 2'd0;
  localparam logic [1:0] SEL_BAT  = 2'd1;
  localparam logic [1:0] SEL_DCDC = 2'd2;

endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cps_presence_filter.sv
module cps_presence_filter #(
  parameter int unsigned DEBOUNCE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic det_sync,
  input  logic pol_hi,
  input  logic enable,
  output logic present,
  output logic change_evt
);
  localparam int unsigned CW = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          raw_present;

  assign raw_present = pol_hi ? det_sync : ~det_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      present    <= 1'b0;
      change_evt <= 1'b0;
    end else begin
      change_evt <= 1'b0;
      if (!enable || (raw_present == present)) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q      <= '0;
        present    <= raw_present;
        change_evt <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cps_irq_latch.sv
module cps_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  output logic irq_n
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign irq_n = ~flag_q;
endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm
  import card_pwr_pkg::*;
#(
  parameter int unsigned STEP_CYC = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cs_n,
  input  logic    pwr_req,
  input  logic    host_rst,
  input  logic    host_io,
  input  logic    card_present,
  input  logic    bat_good,
  input  logic    vcc_good,
  output pwr_st_e state,
  output logic    in_session,
  output logic    vcc_en,
  output logic    clk_en,
  output logic    crd_rst,
  output logic    crd_io
);
  localparam int unsigned SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);

  pwr_st_e       st_q, st_d;
  logic [SW-1:0] step_q;
  logic          pwr_q;
  logic          step_done, abort, host_off, start_req;

  assign step_done = (step_q == STEP_LAST);
  assign abort     = !card_present || !bat_good;
  assign host_off  = !cs_n && !pwr_req;
  assign start_req = !cs_n && pwr_req && !pwr_q && card_present && bat_good;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:    if (start_req) st_d = ST_PWR_UP;
      ST_PWR_UP: begin
        if (abort || host_off) st_d = ST_DN_RST;
        else if (vcc_good)     st_d = ST_ACTIVE;
      end
      ST_ACTIVE: if (abort || host_off) st_d = ST_DN_RST;
      ST_DN_RST: if (step_done) st_d = ST_DN_CLK;
      ST_DN_CLK: if (step_done) st_d = ST_DN_IO;
      ST_DN_IO:  if (step_done) st_d = ST_OFF;
      default:   st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OFF;
      step_q  <= '0;
      pwr_q   <= 1'b0;
      vcc_en  <= 1'b0;
      clk_en  <= 1'b0;
      crd_rst <= 1'b0;
      crd_io  <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= (st_d != st_q) ? '0 : step_q + 1'b1;
      pwr_q   <= pwr_req;
      vcc_en  <= (st_q != ST_OFF);
      clk_en  <= (st_q == ST_ACTIVE) || (st_q == ST_DN_RST);
      crd_rst <= (st_q == ST_ACTIVE) && host_rst;
      crd_io  <= ((st_q == ST_ACTIVE) || (st_q == ST_DN_RST) ||
                  (st_q == ST_DN_CLK)) && host_io;
    end
  end

  assign state      = st_q;
  assign in_session = (st_q != ST_OFF);
endmodule

// File: rtl/cps_status_mux.sv
module cps_status_mux
  import card_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic [1:0] addr,
  input  logic       card_present,
  input  logic       bat_good,
  input  logic       vcc_good,
  output logic       status
);
  logic sel_bit;

  always_comb begin
    case (addr)
      SEL_CARD: sel_bit = card_present;
      SEL_BAT:  sel_bit = ~bat_good;
      SEL_DCDC: sel_bit = vcc_good;
      default:  sel_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 1'b1;
    else     status <= cs_n ? 1'b1 : sel_bit;
  end
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import card_pwr_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 10_000_000,
  parameter int unsigned STEP_CYC     = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       det_in,
  input  logic       pol_hi,
  input  logic       cs_n,
  input  logic       pwr_req,
  input  logic       host_rst,
  input  logic       host_io,
  input  logic       irq_clr,
  input  logic [1:0] addr,
  input  logic       bat_ok,
  input  logic       vcc_good,
  output logic       vcc_en,
  output logic       clk_en,
  output logic       crd_rst,
  output logic       crd_io,
  output logic       irq_n,
  output logic       status
);
  logic    det_s, bat_good, vgood_s, bat_prev_q, bat_drop;
  logic    card_present, pres_evt, in_session, irq_set;
  pwr_st_e fsm_st;

  cps_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({det_in, bat_ok, vcc_good}),
    .q   ({det_s, bat_good, vgood_s})
  );

  always_ff @(posedge clk) begin
    if (rst) bat_prev_q <= 1'b0;
    else     bat_prev_q <= bat_good;
  end
  assign bat_drop = bat_prev_q && !bat_good;

  cps_presence_filter #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_filter (
    .clk        (clk),
    .rst        (rst),
    .det_sync   (det_s),
    .pol_hi     (pol_hi),
    .enable     (bat_good),
    .present    (card_present),
    .change_evt (pres_evt)
  );

  assign irq_set = pres_evt || (bat_drop && in_session);

  cps_irq_latch u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_evt (irq_set),
    .clr     (irq_clr),
    .irq_n   (irq_n)
  );

  cps_seq_fsm #(.STEP_CYC(STEP_CYC)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .pwr_req      (pwr_req),
    .host_rst     (host_rst),
    .host_io      (host_io),
    .card_present (card_present),
    .bat_good     (bat_good),
    .vcc_good     (vgood_s),
    .state        (fsm_st),
    .in_session   (in_session),
    .vcc_en       (vcc_en),
    .clk_en       (clk_en),
    .crd_rst      (crd_rst),
    .crd_io       (crd_io)
  );

  cps_status_mux u_status (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .addr         (addr),
    .card_present (card_present),
    .bat_good     (bat_good),
    .vcc_good     (vgood_s),
    .status       (status)
  );
endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk
  import card_pwr_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    cs_n,
  input logic    vcc_en,
  input logic    clk_en,
  input logic    crd_rst,
  input logic    crd_io,
  input logic    irq_n,
  input logic    status,
  input logic    card_present,
  input logic    bat_good,
  input logic    pres_evt,
  input pwr_st_e fsm_st
);
  AST_CLK_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> vcc_en); // R5
  AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
    crd_io |-> vcc_en); // R5
  AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
    crd_rst |-> clk_en); // R6
  AST_VCC_OFF_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en) |-> (!clk_en && !crd_io && !crd_rst)); // R7
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    pres_evt |=> !irq_n); // R4
  AST_REMOVAL_FORCES_DOWN: assert property (@(posedge clk) disable iff (rst)
    (fsm_st == ST_ACTIVE && !card_present) |=> (fsm_st == ST_DN_RST)); // R8
  AST_START_NEEDS_CARD_BAT: assert property (@(posedge clk) disable iff (rst)
    $rose(vcc_en) |-> $past(card_present && bat_good)); // R9
  AST_STATUS_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> status); // R10
endmodule

bind card_pwr_seq card_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .vcc_en       (vcc_en),
  .clk_en       (clk_en),
  .crd_rst      (crd_rst),
  .crd_io       (crd_io),
  .irq_n        (irq_n),
  .status       (status),
  .card_present (card_present),
  .bat_good     (bat_good),
  .pres_evt     (pres_evt),
  .fsm_st       (fsm_st)
);

// File: tb/card_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module card_pwr_seq_tb_top;
  localparam int DEB  = 20;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic det_in = 1'b1, pol_hi = 1'b0, cs_n = 1'b1, pwr_req = 1'b0;
  logic host_rst = 1'b0, host_io = 1'b1, irq_clr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic bat_ok = 1'b1, vcc_good = 1'b0;
  logic vcc_en, clk_en, crd_rst, crd_io, irq_n, status;

  always #2.5 clk = ~clk;

  card_pwr_seq #(.DEBOUNCE_CYC(DEB), .STEP_CYC(STEP), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .det_in(det_in), .pol_hi(pol_hi), .cs_n(cs_n),
    .pwr_req(pwr_req), .host_rst(host_rst), .host_io(host_io),
    .irq_clr(irq_clr), .addr(addr), .bat_ok(bat_ok), .vcc_good(vcc_good),
    .vcc_en(vcc_en), .clk_en(clk_en), .crd_rst(crd_rst), .crd_io(crd_io),
    .irq_n(irq_n), .status(status)
  );

  typedef struct { logic [4:0] val; int gap; } exp_t;
  exp_t  exp_q[$];
  int    n_chk = 0, n_err = 0, cyc = 0, last_cyc = 0;
  bit    mon_on = 1'b0;
  string cur_req = "R1";
  logic [4:0] prev_b;
  logic [4:0] bundle;

  assign bundle = {vcc_en, clk_en, crd_rst, crd_io, irq_n};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_out(logic [4:0] v, int g);
    exp_t e;
    e.val = v;
    e.gap = g;
    exp_q.push_back(e);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp_v);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic read_status(logic [1:0] a, string req, logic exp_v);
    cs_n = 1'b0;
    addr = a;
    tick(6);
    check(req, {7'd0, status}, {7'd0, exp_v});
  endtask

  // Monitor: every change of the output bundle is matched to the next queued item.
  always @(negedge clk) begin
    if (mon_on && (bundle !== prev_b)) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL %s unexpected output change act=%b exp=%b", cur_req, bundle, prev_b);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (bundle !== e.val) begin
          n_err++;
          $display("FAIL %s output act=%b exp=%b", cur_req, bundle, e.val);
        end
        if (e.gap >= 0) begin
          n_chk++;
          if ((cyc - last_cyc) != e.gap) begin
            n_err++;
            $display("FAIL %s step spacing act=%0d exp=%0d", cur_req, cyc - last_cyc, e.gap);
          end
        end
      end
      last_cyc = cyc;
      prev_b   = bundle;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(10);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1", {3'd0, bundle}, 8'b0000_0001);
    check("R1", {7'd0, status}, 8'd1);
    prev_b = bundle;
    mon_on = 1'b1;

    // R10 status codes, no card, battery good, converter off
    cur_req = "R10";
    read_status(2'd1, "R10", 1'b0);
    read_status(2'd0, "R10", 1'b0);
    read_status(2'd2, "R10", 1'b0);
    vcc_good = 1'b1;
    read_status(2'd2, "R10", 1'b1);
    read_status(2'd3, "R10", 1'b1);
    vcc_good = 1'b0;

    // R11 request without a card
    cur_req = "R11";
    pwr_req = 1'b1;
    tick(20);
    check("R11", {7'd0, vcc_en}, 8'd0);
    pwr_req = 1'b0;

    // R3 short bounce is filtered out
    cur_req = "R3";
    det_in = 1'b0;
    tick(DEB - 5);
    det_in = 1'b1;
    tick(40);
    check("R3", {7'd0, irq_n}, 8'd1);
    read_status(2'd0, "R3", 1'b0);

    // R2 R4 insertion, default polarity
    cur_req = "R4";
    expect_out(5'b00000, -1);
    det_in = 1'b0;
    tick(DEB + 12);
    read_status(2'd0, "R2", 1'b1);
    check("R4", {7'd0, irq_n}, 8'd0);
    expect_out(5'b00001, -1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    tick(4);
    check("R4", {7'd0, irq_n}, 8'd1);

    // R11 request while not selected
    cur_req = "R11";
    cs_n = 1'b1;
    pwr_req = 1'b1;
    tick(20);
    check("R11", {7'd0, vcc_en}, 8'd0);
    pwr_req = 1'b0;
    tick(2);

    // R5 activation waits for supply good
    cur_req = "R5";
    cs_n = 1'b0;
    expect_out(5'b10001, -1);
    pwr_req = 1'b1;
    tick(12);
    check("R5", {6'd0, clk_en, crd_io}, 8'd0);
    expect_out(5'b11011, -1);
    vcc_good = 1'b1;
    tick(8);

    // R6 reset and data follow the host
    cur_req = "R6";
    expect_out(5'b11111, -1);
    host_rst = 1'b1; tick(4);
    expect_out(5'b11101, -1);
    host_io = 1'b0; tick(4);
    expect_out(5'b11111, -1);
    host_io = 1'b1; tick(4);

    // R7 host-requested shutdown order and spacing
    cur_req = "R7";
    expect_out(5'b11011, -1);
    expect_out(5'b10011, STEP);
    expect_out(5'b10001, STEP);
    expect_out(5'b00001, STEP);
    pwr_req = 1'b0;
    tick(3 * STEP + 12);
    check("R7", exp_q.size()[7:0], 8'd0);

    // R8 removal overrides a held power request
    cur_req = "R8";
    host_rst = 1'b0;
    expect_out(5'b10001, -1);
    expect_out(5'b11011, -1);
    pwr_req = 1'b1;
    tick(10);
    expect_out(5'b11111, -1);
    host_rst = 1'b1; tick(4);
    expect_out(5'b11110, -1);
    expect_out(5'b11010, -1);
    expect_out(5'b10010, STEP);
    expect_out(5'b10000, STEP);
    expect_out(5'b00000, STEP);
    det_in = 1'b1;
    tick(DEB + 3 * STEP + 16);
    check("R8", exp_q.size()[7:0], 8'd0);
    check("R8", {7'd0, vcc_en}, 8'd0);
    host_rst = 1'b0;
    expect_out(5'b00001, -1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    pwr_req = 1'b0;
    tick(4);

    // R9 battery drop during a session
    cur_req = "R9";
    expect_out(5'b00000, -1);
    det_in = 1'b0;
    tick(DEB + 12);
    expect_out(5'b00001, -1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    tick(2);
    expect_out(5'b10001, -1);
    expect_out(5'b11011, -1);
    pwr_req = 1'b1;
    tick(10);
    expect_out(5'b11010, -1);
    expect_out(5'b10010, -1);
    expect_out(5'b10000, STEP);
    expect_out(5'b00000, STEP);
    bat_ok = 1'b0;
    tick(3 * STEP + 16);
    check("R9", exp_q.size()[7:0], 8'd0);
    expect_out(5'b00001, -1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    pwr_req = 1'b0; tick(2);
    pwr_req = 1'b1; tick(20);
    check("R9", {7'd0, vcc_en}, 8'd0);
    det_in = 1'b1;
    tick(DEB + 12);
    check("R9", {7'd0, irq_n}, 8'd1);
    read_status(2'd0, "R9", 1'b1);
    read_status(2'd1, "R10", 1'b1);
    pwr_req = 1'b0;

    // Battery back: pending removal is now accepted
    cur_req = "R4";
    expect_out(5'b00000, -1);
    bat_ok = 1'b1;
    tick(DEB + 12);
    read_status(2'd0, "R4", 1'b0);
    expect_out(5'b00001, -1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    tick(2);

    // R2 reversed polarity
    cur_req = "R2";
    expect_out(5'b00000, -1);
    pol_hi = 1'b1;
    tick(DEB + 12);
    read_status(2'd0, "R2", 1'b1);
    expect_out(5'b00001, -1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    tick(2);
    expect_out(5'b00000, -1);
    det_in = 1'b0;
    tick(DEB + 12);
    read_status(2'd0, "R2", 1'b0);
    cs_n = 1'b1;
    tick(4);
    check("R10", {7'd0, status}, 8'd1);

    check("R2", exp_q.size()[7:0], 8'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule